// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block sits in the clock domain of the master audio clock and generates the serial-audio timing for a transmit and a receive serializer. A programmable divider turns the master clock into a bit clock. Two independent frame dividers count bit clocks and produce one frame (word-select) clock for the transmit side and one for the receive side. Alongside the bit clock, it emits one-cycle strobes that mark each rising and falling bit-clock edge, so a framer in the same master-clock domain can shift data without sampling the generated clock.

Software writes every divider field as the wanted ratio minus one. A typical setup uses a master clock at 256 times the sample rate and a stereo 32-bit frame, which means a bit-clock field of 3 (ratio 4) and frame fields of 63 (64 bit clocks). The generator runs only while the master-mode enable is high. When it is low, every output stays low and the serializers take their clocks from outside. A field change made while the block runs is held back until the next frame boundary, so every frame on the wire has a single, whole length.

Top module: `audclk_div`

## Requirements
- R1: During and directly after reset, the bit clock, both frame clocks and both strobes are low.
- R2: A bit-clock period lasts `bclkDivM1 + 1` master-clock cycles. A field value of 0 is treated as 1, so the shortest period is 2 cycles.
- R3: With a bit-clock period of N cycles, the bit clock is high for the first ceil(N/2) cycles of each period and low for the rest. Even ratios therefore give 50% duty, and odd ratios give a high phase one cycle longer than the low phase.
- R4: `bclkRise` is high for exactly the first high cycle of each bit-clock period. `bclkFall` is high for exactly the first low cycle.
- R5: A transmit frame lasts `txFrameM1 + 1` bit-clock periods. `txFs` is low for the first ceil(F/2) bit periods of the frame and high for the rest. It changes only at the start of a bit period, in the same cycle as a rising bit clock.
- R6: The receive frame clock follows the rule in R5 using its own field `rxFrameM1`. Its frame boundaries are independent of the transmit side.
- R7: While `masterEn` is low, all five outputs are low from the cycle after `masterEn` is sampled low. On the first cycle after `masterEn` is sampled high, the bit clock is high, `bclkRise` is high and both frame clocks are low, and this cycle is bit 0 of a new frame on both sides.
- R8: A change of `bclkDivM1` or `txFrameM1` takes effect at the next transmit frame boundary. A change of `rxFrameM1` takes effect at the next receive frame boundary. The frame in progress keeps its old length.
- R9: When generation starts, all three fields are taken from the inputs at once. They do not wait for a frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master audio clock |
| rst_n | input | 1 | Active-low synchronous reset |
| masterEn | input | 1 | 1: generate clocks (master mode); 0: outputs idle (slave mode) |
| bclkDivM1 | input | 8 | Bit-clock divide ratio minus one |
| txFrameM1 | input | 8 | Bit clocks per transmit frame minus one |
| rxFrameM1 | input | 8 | Bit clocks per receive frame minus one |
| bclk | output | 1 | Generated bit clock |
| txFs | output | 1 | Transmit frame clock (low = first half of frame) |
| rxFs | output | 1 | Receive frame clock (low = first half of frame) |
| bclkRise | output | 1 | One-cycle strobe in the first high cycle of the bit clock |
| bclkFall | output | 1 | One-cycle strobe in the first low cycle of the bit clock |

## Verification
The hardest case to reach is a field change that lands mid-frame on a running block. The receive frame has a different length from the transmit frame, so its boundary falls while the old bit ratio is still in force and its next frame is built from bit periods of two different lengths. The stimulus starts the generator with a 4-cycle bit clock, an 8-bit transmit frame and a 6-bit receive frame. It rewrites all three fields ten cycles in, then compares every following cycle against a piecewise arithmetic model of where each boundary must fall. A sweep over bit ratios from 2 to 6, including the zero field, and over several frame lengths from 1 to 64 covers the steady-state waveforms cycle by cycle.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

  // Strobes from the bit-clock control to the frame dividers.
  typedef struct packed {
    logic halt;     // generation disabled this cycle
    logic start;    // first cycle of generation: load fields, restart
    logic run;      // steady-state generation
    logic bitTick;  // last master cycle of a bit period
  } clkStrobes_t;

endpackage

// File: rtl/audclk_bit_ctrl.sv
module audclk_bit_ctrl
  import audclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             masterEn,
  input  logic [DIV_W-1:0] divField,
  input  logic             txWrap,
  output clkStrobes_t      strobes,
  output logic             bclkOut,
  output logic             riseOut,
  output logic             fallOut
);

  localparam int EXT_W = DIV_W + 1;

  logic             runQ;
  logic [DIV_W-1:0] mcntQ;
  logic [DIV_W-1:0] shadowQ;
  logic             bclkQ, riseQ, fallQ;
  logic [EXT_W-1:0] mcntInc;
  logic [EXT_W-1:0] hiLen;
  logic             tick;

  // ratio minus one, with the minimum ratio forced to 2
  function automatic logic [DIV_W-1:0] effM1(input logic [DIV_W-1:0] f);
    return (f == '0) ? DIV_W'(1) : f;
  endfunction

  // high-phase length = ceil((m1+1)/2)
  function automatic logic [EXT_W-1:0] highOf(input logic [DIV_W-1:0] m1);
    return ({1'b0, m1} + EXT_W'(2)) >> 1;
  endfunction

  assign mcntInc = {1'b0, mcntQ} + EXT_W'(1);
  assign hiLen   = highOf(shadowQ);
  assign tick    = runQ && masterEn && (mcntQ == shadowQ);

  assign strobes.halt    = !masterEn;
  assign strobes.start   = masterEn && !runQ;
  assign strobes.run     = runQ && masterEn;
  assign strobes.bitTick = tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      runQ    <= 1'b0;
      mcntQ   <= '0;
      shadowQ <= DIV_W'(1);
      bclkQ   <= 1'b0;
      riseQ   <= 1'b0;
      fallQ   <= 1'b0;
    end else if (!masterEn) begin
      runQ  <= 1'b0;
      mcntQ <= '0;
      bclkQ <= 1'b0;
      riseQ <= 1'b0;
      fallQ <= 1'b0;
    end else if (!runQ) begin
      runQ    <= 1'b1;
      shadowQ <= effM1(divField);
      mcntQ   <= '0;
      bclkQ   <= 1'b1;
      riseQ   <= 1'b1;
      fallQ   <= 1'b0;
    end else if (tick) begin
      mcntQ <= '0;
      bclkQ <= 1'b1;
      riseQ <= 1'b1;
      fallQ <= 1'b0;
      if (txWrap) shadowQ <= effM1(divField);
    end else begin
      mcntQ <= mcntInc[DIV_W-1:0];
      bclkQ <= (mcntInc < hiLen);
      riseQ <= 1'b0;
      fallQ <= (mcntInc == hiLen);
    end
  end

  assign bclkOut = bclkQ;
  assign riseOut = riseQ;
  assign fallOut = fallQ;

  a_r4_rise_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    riseQ |=> !riseQ);
  a_r4_rise_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    riseQ |-> bclkQ);
  a_r4_fall_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    fallQ |-> !bclkQ);
  a_r3_rise_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclkQ) |-> riseQ);
  a_r7_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !masterEn |=> (!bclkQ && !riseQ && !fallQ));
  a_r8_ratio_held: assert property (@(posedge clk) disable iff (!rst_n)
    (runQ && masterEn && !txWrap) |=> $stable(shadowQ));
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    mcntQ <= shadowQ);

endmodule

// File: rtl/audclk_frame_div.sv
module audclk_frame_div
  import audclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  clkStrobes_t      strobes,
  input  logic [DIV_W-1:0] frameField,
  output logic             fsOut,
  output logic             wrap
);

  localparam int EXT_W = DIV_W + 1;

  logic [DIV_W-1:0] cntQ;
  logic [DIV_W-1:0] shadowQ;
  logic             fsQ;
  logic [EXT_W-1:0] cntInc;
  logic [EXT_W-1:0] halfLen;

  assign cntInc  = {1'b0, cntQ} + EXT_W'(1);
  assign halfLen = ({1'b0, shadowQ} + EXT_W'(2)) >> 1;
  assign wrap    = strobes.run && strobes.bitTick && (cntQ == shadowQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntQ    <= '0;
      shadowQ <= '0;
      fsQ     <= 1'b0;
    end else if (strobes.halt) begin
      cntQ <= '0;
      fsQ  <= 1'b0;
    end else if (strobes.start) begin
      shadowQ <= frameField;
      cntQ    <= '0;
      fsQ     <= 1'b0;
    end else if (strobes.run && strobes.bitTick) begin
      if (cntQ == shadowQ) begin
        cntQ    <= '0;
        shadowQ <= frameField;
        fsQ     <= 1'b0;
      end else begin
        cntQ <= cntInc[DIV_W-1:0];
        fsQ  <= (cntInc >= halfLen);
      end
    end
  end

  assign fsOut = fsQ;

  a_r7_fs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.halt |=> !fsQ);
  a_r5_fs_low_new_frame: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> !fsQ);
  a_r5_fs_moves_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fsQ) |-> $past(strobes.bitTick || strobes.halt));
  a_r8_length_held: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.run && !wrap) |=> $stable(shadowQ));

endmodule

// File: rtl/audclk_div.sv
module audclk_div
  import audclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             masterEn,
  input  logic [DIV_W-1:0] bclkDivM1,
  input  logic [DIV_W-1:0] txFrameM1,
  input  logic [DIV_W-1:0] rxFrameM1,
  output logic             bclk,
  output logic             txFs,
  output logic             rxFs,
  output logic             bclkRise,
  output logic             bclkFall
);

  localparam int N_SIDES = 2;  // 0 = transmit, 1 = receive

  clkStrobes_t      strobes;
  logic [DIV_W-1:0] frameFields [N_SIDES];
  logic             fsVec       [N_SIDES];
  logic             wrapVec     [N_SIDES];

  assign frameFields[0] = txFrameM1;
  assign frameFields[1] = rxFrameM1;

  audclk_bit_ctrl #(.DIV_W(DIV_W)) ctrl_i (
    .clk      (mclk),
    .rst_n    (rst_n),
    .masterEn (masterEn),
    .divField (bclkDivM1),
    .txWrap   (wrapVec[0]),
    .strobes  (strobes),
    .bclkOut  (bclk),
    .riseOut  (bclkRise),
    .fallOut  (bclkFall)
  );

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    audclk_frame_div #(.DIV_W(DIV_W)) frame_i (
      .clk        (mclk),
      .rst_n      (rst_n),
      .strobes    (strobes),
      .frameField (frameFields[s]),
      .fsOut      (fsVec[s]),
      .wrap       (wrapVec[s])
    );
  end

  assign txFs = fsVec[0];
  assign rxFs = fsVec[1];

endmodule

// File: tb/audclk_div_tb_top.sv
module audclk_div_tb_top;

  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       masterEn = 1'b0;
  logic [7:0] bclkDivM1 = 8'd3;
  logic [7:0] txFrameM1 = 8'd7;
  logic [7:0] rxFrameM1 = 8'd7;
  logic       bclk, txFs, rxFs, bclkRise, bclkFall;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit done    = 0;

  always #4 mclk = ~mclk;  // 125 MHz

  audclk_div dut_i (
    .mclk(mclk), .rst_n(rst_n), .masterEn(masterEn),
    .bclkDivM1(bclkDivM1), .txFrameM1(txFrameM1), .rxFrameM1(rxFrameM1),
    .bclk(bclk), .txFs(txFs), .rxFs(rxFs),
    .bclkRise(bclkRise), .bclkFall(bclkFall)
  );

  task automatic check(input string req, input int got, input int exp, input int k);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, k, got, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  always @(posedge mclk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finishRun();
    end
  end

  function automatic int ceilHalf(input int n);
    return (n + 1) / 2;
  endfunction

  // compare the five outputs with the expected phase state of cycle k
  task automatic checkCycle(input int k, input int n, input int p,
                            input int ftx, input int ptx,
                            input int frx, input int prx);
    check("R2/R3 bclk", bclk, (p < ceilHalf(n)) ? 1 : 0, k);
    check("R4 rise", bclkRise, (p == 0) ? 1 : 0, k);
    check("R4 fall", bclkFall, (p == ceilHalf(n)) ? 1 : 0, k);
    check("R5 txFs", txFs, (ptx >= ceilHalf(ftx)) ? 1 : 0, k);
    check("R6 rxFs", rxFs, (prx >= ceilHalf(frx)) ? 1 : 0, k);
  endtask

  // enable generation; returns after the edge that yields cycle 0
  task automatic startGen();
    @(negedge mclk);
    masterEn = 1'b1;
    @(posedge mclk);
  endtask

  task automatic stopGen();
    @(negedge mclk);
    masterEn = 1'b0;
    @(negedge mclk);
    check("R7 idle bclk", bclk, 0, -1);
    check("R7 idle txFs", txFs, 0, -1);
    check("R7 idle rxFs", rxFs, 0, -1);
    check("R7 idle strobes", {bclkRise, bclkFall}, 0, -1);
  endtask

  task automatic sweepOne(input int divF, input int txF, input int rxF);
    int n, ftx, frx, len;
    n   = (divF == 0) ? 2 : divF + 1;
    ftx = txF + 1;
    frx = rxF + 1;
    @(negedge mclk);
    bclkDivM1 = 8'(divF);
    txFrameM1 = 8'(txF);
    rxFrameM1 = 8'(rxF);
    startGen();  // R9: fields used from cycle 0
    len = 2 * n * ((ftx > frx) ? ftx : frx);
    for (int k = 0; k < len; k++) begin
      @(negedge mclk);
      checkCycle(k, n, k % n, ftx, (k / n) % ftx, frx, (k / n) % frx);
    end
    stopGen();
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge mclk);
    check("R1 bclk", bclk, 0, 0);
    check("R1 frames", {txFs, rxFs}, 0, 0);
    check("R1 strobes", {bclkRise, bclkFall}, 0, 0);
    rst_n = 1'b1;
    @(negedge mclk);
    check("R1 after reset", {bclk, txFs, rxFs, bclkRise, bclkFall}, 0, 0);

    // R7: fields ignored while disabled; outputs stay low
    for (int i = 0; i < 8; i++) begin
      bclkDivM1 = 8'(i);
      txFrameM1 = 8'(i * 3);
      @(negedge mclk);
      check("R7 slave quiet", {bclk, txFs, rxFs, bclkRise, bclkFall}, 0, i);
    end

    // R2..R6, R9: sweep of bit ratios (field 0 -> ratio 2) and frame sizes
    for (int d = 0; d <= 5; d++) begin
      sweepOne(d, 0, 2);
      sweepOne(d, 3, 6);
      sweepOne(d, 6, 3);
      sweepOne(d, 63, 31);
    end

    // R8: mid-frame change, deferred to each side's frame boundary
    @(negedge mclk);
    bclkDivM1 = 8'd3;
    txFrameM1 = 8'd7;
    rxFrameM1 = 8'd5;
    startGen();
    for (int k = 0; k < 112; k++) begin
      int n, p, b, ptx, ftx, prx, frx;
      @(negedge mclk);
      if (k < 32) begin
        n = 4; p = k % 4; b = k / 4;
        ftx = 8; ptx = b % 8;
      end else begin
        n = 2; p = (k - 32) % 2; b = 8 + (k - 32) / 2;
        ftx = 4; ptx = (b - 8) % 4;
      end
      if (b < 6) begin
        frx = 6; prx = b;
      end else begin
        frx = 10; prx = (b - 6) % 10;
      end
      checkCycle(k, n, p, ftx, ptx, frx, prx);
      if (k == 10) begin
        bclkDivM1 = 8'd1;
        txFrameM1 = 8'd3;
        rxFrameM1 = 8'd9;
      end
    end
    stopGen();

    finishRun();
  end

endmodule